// File: doc/BRIEF.md
# Reset Cause Recorder and Software Reset Sequencer

This block keeps a record of what caused the most recent reset. It also lets software request two kinds of one-shot reset. Five single-cycle event inputs report a reset cause: power-up, the external reset pin, the watchdog, the brown-out monitor and a system-reset request from the processor core. Each event latches its own bit in a status register. A bit stays set until software writes a 1 to it. The status register sits in an always-on reset domain (`aon_rst_n`), so the chip-level reset it records does not wipe it.

A control register holds two self-clearing trigger bits and one flash wait-state select bit. The trigger bits are protected: a write of 1 to either one is accepted only while the external `unlock_ok` input is high. An accepted trigger starts a one-shot sequencer that drives its reset output high for `PULSE_CYCLES` clock cycles and latches the matching cause flag. Each sequencer has two states. It waits in `OS_IDLE`. An accepted start moves it to `OS_PULSE` and loads a down-counter with `PULSE_CYCLES-1`. In `OS_PULSE` the counter decrements once per cycle. When it reaches zero the sequencer returns to `OS_IDLE`. The register bus is a simple write strobe with address and data, and the read data path is combinational from the address.

Top module: `rst_cause_ctrl`

## Requirements
- R1: After both resets, the status register (address 0) and the control register (address 1) read 0, and `chip_rst_o`, `cpu_rst_o` and `flash_nowait_o` are low.
- R2: A one-cycle pulse on an event input sets its status bit, and the bit is visible from the next cycle. The bit positions are: power-up on bit 0, pin on bit 1, watchdog on bit 2, brown-out on bit 4, core request on bit 5. Bits 3 and 6 always read 0.
- R3: A status bit clears only when software writes to address 0 with a 1 in that bit position. Bits written as 0 keep their value.
- R4: If an event and a write-1-to-clear of the same bit fall in the same cycle, the bit ends up set.
- R5: A write to address 1 with bit 0 set, while `unlock_ok` is high, drives `chip_rst_o` high starting the cycle after the write. The same write sets status bit 0.
- R6: A write to address 1 with bit 1 set, while `unlock_ok` is high, drives `cpu_rst_o` high starting the cycle after the write. The same write sets status bit 7.
- R7: While `unlock_ok` is low, writes of 1 to control bits 0 and 1 are ignored. No reset pulse follows and no flag is set.
- R8: Each reset output stays high for exactly `PULSE_CYCLES` cycles (default 2). Control bits 0 and 1 read 1 during those cycles and return to 0 by themselves afterwards.
- R9: Control bit 2 is writable whether `unlock_ok` is high or low, reads back as written, and drives `flash_nowait_o`. A value of 1 means no flash wait state and 0 means one wait state.
- R10: `rst_n` clears the control register and both sequencers but leaves the status flags intact. `aon_rst_n` clears the status flags.
- R11: A write of 1 to a trigger bit while that trigger's pulse is active neither restarts nor lengthens the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| aon_rst_n | input | 1 | Always-on domain reset, active low, clears the status flags |
| rst_n | input | 1 | Functional reset, active low, clears the control register and sequencers |
| ev_por | input | 1 | Power-up reset event pulse |
| ev_pin | input | 1 | External pin reset event pulse |
| ev_wdt | input | 1 | Watchdog reset event pulse |
| ev_bod | input | 1 | Brown-out reset event pulse |
| ev_sysreq | input | 1 | Core system-reset request event pulse |
| unlock_ok | input | 1 | High while protected control bits may be written |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (2) | Register address: 0 status, 1 control |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Read data for `bus_addr` |
| chip_rst_o | output | 1 | Chip-wide soft reset pulse |
| cpu_rst_o | output | 1 | CPU-only soft reset pulse |
| flash_nowait_o | output | 1 | 1 selects no flash wait state |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 2-bit address and a pulse length of two cycles. With this small configuration the bench can try all 256 write-1-to-clear patterns against a fully set status register. It also covers every combination of the three control bits with the unlock input both high and low. For each of these control cases the bench checks both reset outputs and the control read-back cycle by cycle, then checks the cause flags that result.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
    localparam int FLG_POR    = 0;
    localparam int FLG_PIN    = 1;
    localparam int FLG_WDT    = 2;
    localparam int FLG_BOD    = 4;
    localparam int FLG_SYSREQ = 5;
    localparam int FLG_CPU    = 7;

    localparam int CTL_CHIP   = 0;
    localparam int CTL_CPU    = 1;
    localparam int CTL_NOWAIT = 2;

    localparam int ADDR_STATUS = 0;
    localparam int ADDR_CTRL   = 1;

    localparam int NUM_SHOTS = 2;

    typedef enum logic [0:0] {
        OS_IDLE  = 1'b0,
        OS_PULSE = 1'b1
    } os_state_e;
endpackage

// File: rtl/rcc_oneshot.sv
module rcc_oneshot
    import rcc_pkg::*;
#(
    parameter int PULSE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic accept_o,
    output logic pulse_o
);
    localparam int CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES - 1);

    os_state_e        state_q, state_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        unique case (state_q)
            OS_IDLE: begin
                if (start_i) begin
                    state_nx = OS_PULSE;
                    cnt_nx   = CNT_LOAD;
                end
            end
            OS_PULSE: begin
                if (cnt_q == '0) begin
                    state_nx = OS_IDLE;
                end else begin
                    cnt_nx = cnt_q - 1'b1;
                end
            end
            default: state_nx = OS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pulse_o  = (state_q == OS_PULSE);
        accept_o = (state_q == OS_IDLE) && start_i;
    end
endmodule

// File: rtl/rcc_flags.sv
module rcc_flags #(
    parameter int              DATA_W    = 8,
    parameter logic [DATA_W-1:0] FLAG_MASK = '1
) (
    input  logic              clk,
    input  logic              aon_rst_n,
    input  logic [DATA_W-1:0] set_i,
    input  logic [DATA_W-1:0] clr_i,
    output logic [DATA_W-1:0] flags_o
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (FLAG_MASK[b]) begin : g_flop
            logic flag_q;
            always_ff @(posedge clk or negedge aon_rst_n) begin
                if (!aon_rst_n) begin
                    flag_q <= 1'b0;
                end else if (set_i[b]) begin
                    flag_q <= 1'b1;
                end else if (clr_i[b]) begin
                    flag_q <= 1'b0;
                end
            end
            assign flags_o[b] = flag_q;
        end else begin : g_tie
            assign flags_o[b] = 1'b0;
        end
    end
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
    import rcc_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 2,
    parameter int PULSE_CYCLES = 2
) (
    input  logic              clk,
    input  logic              aon_rst_n,
    input  logic              rst_n,
    input  logic              ev_por,
    input  logic              ev_pin,
    input  logic              ev_wdt,
    input  logic              ev_bod,
    input  logic              ev_sysreq,
    input  logic              unlock_ok,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              chip_rst_o,
    output logic              cpu_rst_o,
    output logic              flash_nowait_o
);
    localparam logic [DATA_W-1:0] FLAG_MASK =
        (DATA_W'(1) << FLG_POR) | (DATA_W'(1) << FLG_PIN) | (DATA_W'(1) << FLG_WDT) |
        (DATA_W'(1) << FLG_BOD) | (DATA_W'(1) << FLG_SYSREQ) | (DATA_W'(1) << FLG_CPU);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADDR_STATUS);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(ADDR_CTRL);

    logic                 wr_status, wr_ctrl;
    logic [NUM_SHOTS-1:0] shot_start, shot_accept, shot_pulse;
    logic [DATA_W-1:0]    set_vec, clr_vec, flag_vec, ctrl_rd;
    logic                 nowait_q;

    assign wr_status = bus_wr && (bus_addr == A_STATUS);
    assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);

    // protected trigger requests
    assign shot_start[0] = wr_ctrl && bus_wdata[CTL_CHIP] && unlock_ok;
    assign shot_start[1] = wr_ctrl && bus_wdata[CTL_CPU]  && unlock_ok;

    for (genvar s = 0; s < NUM_SHOTS; s++) begin : g_shot
        rcc_oneshot #(
            .PULSE_CYCLES(PULSE_CYCLES)
        ) u_shot (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  (shot_start[s]),
            .accept_o (shot_accept[s]),
            .pulse_o  (shot_pulse[s])
        );
    end

    always_comb begin
        set_vec             = '0;
        set_vec[FLG_POR]    = ev_por | shot_accept[0];
        set_vec[FLG_PIN]    = ev_pin;
        set_vec[FLG_WDT]    = ev_wdt;
        set_vec[FLG_BOD]    = ev_bod;
        set_vec[FLG_SYSREQ] = ev_sysreq;
        set_vec[FLG_CPU]    = shot_accept[1];
        clr_vec             = wr_status ? bus_wdata : '0;
    end

    rcc_flags #(
        .DATA_W    (DATA_W),
        .FLAG_MASK (FLAG_MASK)
    ) u_flags (
        .clk       (clk),
        .aon_rst_n (aon_rst_n),
        .set_i     (set_vec),
        .clr_i     (clr_vec),
        .flags_o   (flag_vec)
    );

    // wait-state select, not protected
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nowait_q <= 1'b0;
        end else if (wr_ctrl) begin
            nowait_q <= bus_wdata[CTL_NOWAIT];
        end
    end

    always_comb begin
        ctrl_rd             = '0;
        ctrl_rd[CTL_CHIP]   = shot_pulse[0];
        ctrl_rd[CTL_CPU]    = shot_pulse[1];
        ctrl_rd[CTL_NOWAIT] = nowait_q;
        if (bus_addr == A_STATUS) begin
            bus_rdata = flag_vec;
        end else if (bus_addr == A_CTRL) begin
            bus_rdata = ctrl_rd;
        end else begin
            bus_rdata = '0;
        end
    end

    assign chip_rst_o     = shot_pulse[0];
    assign cpu_rst_o      = shot_pulse[1];
    assign flash_nowait_o = nowait_q;
endmodule

// File: rtl/rst_cause_ctrl_chk.sv
module rst_cause_ctrl_chk #(
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 2,
    parameter int PULSE_CYCLES = 2
) (
    input logic              clk,
    input logic              aon_rst_n,
    input logic              rst_n,
    input logic              ev_wdt,
    input logic              unlock_ok,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              chip_rst_o,
    input logic              cpu_rst_o,
    input logic [DATA_W-1:0] flags
);
    logic [DATA_W-1:0] clr_seen;
    int unsigned       chip_run_q, cpu_run_q;

    assign clr_seen = (bus_wr && bus_addr == ADDR_W'(0)) ? bus_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chip_run_q <= 0;
            cpu_run_q  <= 0;
        end else begin
            chip_run_q <= chip_rst_o ? chip_run_q + 1 : 0;
            cpu_run_q  <= cpu_rst_o  ? cpu_run_q + 1  : 0;
        end
    end

    // R3: a set flag drops only where a 1 was written to it
    p_sticky_r3: assert property (@(posedge clk) disable iff (!aon_rst_n)
        (((($past(flags) & ~$past(clr_seen)) & ~flags)) == '0));

    // R4: event wins over simultaneous clear
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!aon_rst_n)
        ev_wdt |=> flags[2]);

    // R5: chip pulse start comes with the power-up flag
    p_chip_flag_r5: assert property (@(posedge clk) disable iff (!aon_rst_n || !rst_n)
        $rose(chip_rst_o) |-> flags[0]);

    // R6: cpu pulse start comes with the cpu flag
    p_cpu_flag_r6: assert property (@(posedge clk) disable iff (!aon_rst_n || !rst_n)
        $rose(cpu_rst_o) |-> flags[7]);

    // R7: locked write does not start a chip pulse
    p_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(1) && bus_wdata[0] && !unlock_ok && !chip_rst_o)
        |=> !chip_rst_o);

    // R8: pulses never exceed and always reach the fixed length
    p_chip_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_o |-> (chip_run_q < PULSE_CYCLES));
    p_chip_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_rst_o && chip_run_q != 0) |-> (chip_run_q == PULSE_CYCLES));
    p_cpu_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst_o |-> (cpu_run_q < PULSE_CYCLES));
    p_cpu_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rst_o && cpu_run_q != 0) |-> (cpu_run_q == PULSE_CYCLES));
endmodule

bind rst_cause_ctrl rst_cause_ctrl_chk #(
    .DATA_W       (DATA_W),
    .ADDR_W       (ADDR_W),
    .PULSE_CYCLES (PULSE_CYCLES)
) u_chk (
    .clk        (clk),
    .aon_rst_n  (aon_rst_n),
    .rst_n      (rst_n),
    .ev_wdt     (ev_wdt),
    .unlock_ok  (unlock_ok),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .chip_rst_o (chip_rst_o),
    .cpu_rst_o  (cpu_rst_o),
    .flags      (flag_vec)
);

// File: tb/sim_rst_cause_ctrl.sv
`timescale 1ns/1ps
module sim_rst_cause_ctrl;
    logic       clk = 1'b0;
    logic       aon_rst_n = 1'b0, rst_n = 1'b0;
    logic       ev_por = 0, ev_pin = 0, ev_wdt = 0, ev_bod = 0, ev_sysreq = 0;
    logic       unlock_ok = 0, bus_wr = 0;
    logic [1:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       chip_rst_o, cpu_rst_o, flash_nowait_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] rv;

    always #2.5 clk = ~clk;

    rst_cause_ctrl u0 (
        .clk(clk), .aon_rst_n(aon_rst_n), .rst_n(rst_n),
        .ev_por(ev_por), .ev_pin(ev_pin), .ev_wdt(ev_wdt), .ev_bod(ev_bod),
        .ev_sysreq(ev_sysreq), .unlock_ok(unlock_ok), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .chip_rst_o(chip_rst_o), .cpu_rst_o(cpu_rst_o), .flash_nowait_o(flash_nowait_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_ev(input int idx);
        case (idx)
            0: ev_por = 1;
            1: ev_pin = 1;
            2: ev_wdt = 1;
            3: ev_bod = 1;
            default: ev_sysreq = 1;
        endcase
        @(negedge clk);
        {ev_por, ev_pin, ev_wdt, ev_bod, ev_sysreq} = '0;
    endtask

    task automatic set_all();
        {ev_por, ev_pin, ev_wdt, ev_bod, ev_sysreq} = '1;
        @(negedge clk);
        {ev_por, ev_pin, ev_wdt, ev_bod, ev_sysreq} = '0;
        unlock_ok = 1;
        wr(2'd1, 8'h02);
        unlock_ok = 0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] bitpos [5];
        bitpos[0] = 8'h01; bitpos[1] = 8'h02; bitpos[2] = 8'h04;
        bitpos[3] = 8'h10; bitpos[4] = 8'h20;

        repeat (3) @(negedge clk);
        aon_rst_n = 1; rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, rv); check("R1 status", rv, 8'h00);
        rd(2'd1, rv); check("R1 ctrl", rv, 8'h00);
        check("R1 outputs", {5'd0, chip_rst_o, cpu_rst_o, flash_nowait_o}, 8'h00);

        // R2 each event sets its own bit only
        for (int i = 0; i < 5; i++) begin
            pulse_ev(i);
            rd(2'd0, rv); check("R2 event flag", rv, bitpos[i]);
            wr(2'd0, 8'hFF);
            rd(2'd0, rv); check("R3 cleared", rv, 8'h00);
        end

        // R3 zero writes and unused bits do nothing
        set_all();
        rd(2'd0, rv); check("R2 all flags", rv, 8'hB7);
        wr(2'd0, 8'h00);
        rd(2'd0, rv); check("R3 write zero", rv, 8'hB7);
        wr(2'd0, 8'h48);
        rd(2'd0, rv); check("R3 unused bits", rv, 8'hB7);

        // R3 full sweep of clear patterns
        for (int p = 0; p < 256; p++) begin
            set_all();
            wr(2'd0, 8'(p));
            rd(2'd0, rv); check("R3 w1c sweep", rv, 8'hB7 & ~8'(p));
        end
        wr(2'd0, 8'hFF);

        // R4 set beats clear in the same cycle
        ev_wdt = 1;
        wr(2'd0, 8'h04);
        ev_wdt = 0;
        rd(2'd0, rv); check("R4 set wins", rv, 8'h04);
        ev_wdt = 1;
        wr(2'd0, 8'h04);
        ev_wdt = 0;
        rd(2'd0, rv); check("R4 set wins held", rv, 8'h04);
        wr(2'd0, 8'hFF);

        // R5 R6 R7 R8 R9 control sweep
        for (int u = 0; u < 2; u++) begin
            for (int d = 0; d < 8; d++) begin
                logic ec, ep, ew;
                ec = (u == 1) && d[0];
                ep = (u == 1) && d[1];
                ew = d[2];
                wr(2'd0, 8'hFF);
                unlock_ok = (u == 1);
                wr(2'd1, 8'(d));
                unlock_ok = 0;
                check("R5 chip pulse cycle1", {7'd0, chip_rst_o}, {7'd0, ec});
                check("R6 cpu pulse cycle1", {7'd0, cpu_rst_o}, {7'd0, ep});
                rd(2'd1, rv); check("R8 ctrl during pulse", rv, {5'd0, ew, ep, ec});
                @(negedge clk);
                check("R8 chip pulse cycle2", {7'd0, chip_rst_o}, {7'd0, ec});
                check("R8 cpu pulse cycle2", {7'd0, cpu_rst_o}, {7'd0, ep});
                @(negedge clk);
                check("R8 pulses ended", {6'd0, chip_rst_o, cpu_rst_o}, 8'h00);
                rd(2'd1, rv); check("R9 ctrl after pulse", rv, {5'd0, ew, 2'b00});
                check("R9 nowait out", {7'd0, flash_nowait_o}, {7'd0, ew});
                rd(2'd0, rv);
                check(u == 1 ? "R5 R6 flags" : "R7 no flags", rv, {ep, 6'd0, ec});
            end
        end

        // R11 retrigger during a pulse is ignored
        wr(2'd0, 8'hFF);
        unlock_ok = 1;
        wr(2'd1, 8'h01);
        check("R11 first cycle", {7'd0, chip_rst_o}, 8'h01);
        wr(2'd1, 8'h01);
        check("R11 second cycle", {7'd0, chip_rst_o}, 8'h01);
        @(negedge clk);
        unlock_ok = 0;
        check("R11 not extended", {7'd0, chip_rst_o}, 8'h00);
        @(negedge clk);
        check("R11 no restart", {7'd0, chip_rst_o}, 8'h00);

        // R10 functional reset keeps flags, always-on reset clears them
        wr(2'd0, 8'hFF);
        set_all();
        wr(2'd1, 8'h04);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        rd(2'd0, rv); check("R10 flags survive", rv, 8'hB7);
        rd(2'd1, rv); check("R10 ctrl cleared", rv, 8'h00);
        check("R10 nowait cleared", {7'd0, flash_nowait_o}, 8'h00);
        aon_rst_n = 0;
        @(negedge clk);
        aon_rst_n = 1;
        @(negedge clk);
        rd(2'd0, rv); check("R10 aon clears flags", rv, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule